// File: doc/BRIEF.md
# Serial Link Loopback Tester

This block is a built-in self-test sequencer for a byte-wide serial transmitter/receiver pair. The pair is wired in loopback. After a start pulse it sends a burst of exactly one hundred characters into the transmit interface, using an incrementing byte pattern. It compares every character that comes back against the value it expects next, and it sorts failures into three sticky classes: receiver overrun, receiver parity error and data mismatch. A separate flag records a receive timeout, which ends the run when characters stop arriving.

The transmitter is throttled so that only a small number of characters can be in flight at once. A slow link therefore cannot overrun the receiver through the tester's own doing. Once the run ends, a pass output and one status LED bit report whether all hundred characters came back clean. A new start pulse clears every flag and runs the burst again.

Top module: `serial_loopback_tester`

## Requirements
- R1: After reset, tx_valid_o, busy_o, done_o, pass_o, all four error flags and led_o are all 0.
- R2: A start_i pulse while idle or done clears all flags and counters and begins a run (busy_o is 1 on the next cycle). A start_i pulse during a run has no effect on that run.
- R3: A run offers exactly NUM_CHARS (100) characters with values 0x00, 0x01, 0x02 and so on, in that order. While tx_ready_i is low, tx_valid_o and tx_data_o hold steady.
- R4: Characters accepted by the transmitter minus characters received never exceeds MAX_INFLIGHT (2).
- R5: A received character with rx_overrun_i set raises err_overrun_o, which stays 1 until the next start.
- R6: A received character with rx_parity_err_i set raises err_parity_o, which stays 1 until the next start.
- R7: A received character whose byte differs from the count of characters received before it (modulo 256) raises err_data_o, which stays 1 until the next start.
- R8: When the hundredth character has been received, the run ends: done_o is 1 and busy_o is 0. pass_o is 1 exactly when no error flag is set.
- R9: If no character is received for TIMEOUT_CYCLES cycles during a run, err_timeout_o and done_o go to 1 and pass_o stays 0.
- R10: led_o bit 5 equals pass_o, and all other led_o bits are 0.
- R11: A character presented on rx_valid_i while no run is active changes no flag and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a test run |
| tx_valid_o | output | 1 | Transmit character offered |
| tx_data_o | output | 8 | Transmit character |
| tx_ready_i | input | 1 | Transmitter accepts the offered character |
| rx_valid_i | input | 1 | Received character present (one cycle each) |
| rx_data_i | input | 8 | Received character |
| rx_parity_err_i | input | 1 | Parity error on this received character |
| rx_overrun_i | input | 1 | Overrun reported with this received character |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished; result outputs valid |
| pass_o | output | 1 | Run finished with no error |
| err_overrun_o | output | 1 | Sticky overrun flag |
| err_parity_o | output | 1 | Sticky parity flag |
| err_data_o | output | 1 | Sticky data-mismatch flag |
| err_timeout_o | output | 1 | Receive timeout flag |
| led_o | output | 8 | Status LEDs; bit 5 shows pass |

## Verification
The assertions assume the receive side never returns more characters than the transmitter accepted. They also assume each received character is marked by a single-cycle rx_valid_i, while tx_ready_i may toggle freely. The loopback model in the bench keeps to this: it delivers only bytes it captured at a transmit handshake, after a fixed latency, one per cycle. Stray characters are injected only while no run is active. Error injection changes the byte or the flags of a chosen delivered character, or stops delivery after a chosen count.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } slt_state_e;
endpackage

// File: rtl/slt_tx_gen.sv
module slt_tx_gen #(
  parameter int NUM_CHARS    = 100,
  parameter int MAX_INFLIGHT = 2,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic              tx_ready,
  input  logic              rx_seen,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              sent_all
);
  localparam int CNT_W = $clog2(NUM_CHARS + 1);
  localparam int INF_W = $clog2(MAX_INFLIGHT + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(NUM_CHARS);
  localparam logic [INF_W-1:0] INF_MAX = INF_W'(MAX_INFLIGHT);

  logic [CNT_W-1:0] sent_q;
  logic [INF_W-1:0] infl_q;
  logic             fire;

  assign sent_all = (sent_q == CNT_END);
  assign tx_valid = run && !sent_all && (infl_q < INF_MAX);
  assign tx_data  = DATA_W'(sent_q);
  assign fire     = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sent_q <= '0;
      infl_q <= '0;
    end else begin
      if (fire) sent_q <= sent_q + 1'b1;
      if (fire && !rx_seen) begin
        infl_q <= infl_q + 1'b1;
      end else if (!fire && rx_seen && (infl_q != '0)) begin
        infl_q <= infl_q - 1'b1;
      end
    end
  end

  // R4
  infl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    infl_q <= INF_MAX);

  // R3
  tx_count_chk: assert property (@(posedge clk) disable iff (rst)
    sent_q <= CNT_END);

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !clear) |=> (!run || (tx_valid && $stable(tx_data))));
endmodule

// File: rtl/slt_rx_check.sv
module slt_rx_check #(
  parameter int NUM_CHARS = 100,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_parity_err,
  input  logic              rx_overrun,
  output logic              rx_seen,
  output logic              got_all,
  output logic              err_overrun,
  output logic              err_parity,
  output logic              err_data
);
  localparam int CNT_W = $clog2(NUM_CHARS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(NUM_CHARS);

  logic [CNT_W-1:0]  rcvd_q;
  logic [DATA_W-1:0] expect_byte;

  assign got_all     = (rcvd_q == CNT_END);
  assign rx_seen     = run && rx_valid && !got_all;
  assign expect_byte = DATA_W'(rcvd_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rcvd_q      <= '0;
      err_overrun <= 1'b0;
      err_parity  <= 1'b0;
      err_data    <= 1'b0;
    end else if (rx_seen) begin
      rcvd_q <= rcvd_q + 1'b1;
      if (rx_overrun)              err_overrun <= 1'b1;
      if (rx_parity_err)           err_parity  <= 1'b1;
      if (rx_data != expect_byte)  err_data    <= 1'b1;
    end
  end

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_overrun && !clear) |=> err_overrun);

  // R6
  par_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_parity && !clear) |=> err_parity);

  // R7
  data_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_data && !clear) |=> err_data);

  // R11
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(rcvd_q));
endmodule

// File: rtl/slt_timeout.sv
module slt_timeout #(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic kick,
  output logic expired
);
  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYCLES - 1);
  localparam logic [TO_W-1:0] TO_FULL = TO_W'(TIMEOUT_CYCLES);

  logic [TO_W-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idle_q  <= '0;
      expired <= 1'b0;
    end else if (kick) begin
      idle_q <= '0;
    end else if (run && !expired) begin
      idle_q <= idle_q + 1'b1;
      if (idle_q == TO_LAST) expired <= 1'b1;
    end
  end

  // R9
  to_bound_chk: assert property (@(posedge clk) disable iff (rst)
    idle_q <= TO_FULL);

  // R9
  to_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !clear) |=> expired);
endmodule

// File: rtl/serial_loopback_tester.sv
module serial_loopback_tester
  import slt_pkg::*;
#(
  parameter int NUM_CHARS      = 100,
  parameter int MAX_INFLIGHT   = 2,
  parameter int TIMEOUT_CYCLES = 1000,
  parameter int DATA_W         = 8,
  parameter int LED_W          = 8,
  parameter int PASS_LED_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_parity_err_i,
  input  logic              rx_overrun_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              err_overrun_o,
  output logic              err_parity_o,
  output logic              err_data_o,
  output logic              err_timeout_o,
  output logic [LED_W-1:0]  led_o
);
  slt_state_e       state_q;
  logic             run, start_go, finish, pass_next;
  logic             rx_seen, got_all, sent_all, expired;
  logic             pass_q;
  logic [LED_W-1:0] led_q;

  assign run       = (state_q == ST_RUN);
  assign start_go  = start_i && !run;
  assign finish    = run && (got_all || expired);
  assign pass_next = got_all && !expired && !err_overrun_o && !err_parity_o && !err_data_o;

  slt_tx_gen #(
    .NUM_CHARS(NUM_CHARS), .MAX_INFLIGHT(MAX_INFLIGHT), .DATA_W(DATA_W)
  ) u_tx (
    .clk(clk), .rst(rst), .clear(start_go), .run(run),
    .tx_ready(tx_ready_i), .rx_seen(rx_seen),
    .tx_valid(tx_valid_o), .tx_data(tx_data_o), .sent_all(sent_all)
  );

  slt_rx_check #(
    .NUM_CHARS(NUM_CHARS), .DATA_W(DATA_W)
  ) u_rx (
    .clk(clk), .rst(rst), .clear(start_go), .run(run),
    .rx_valid(rx_valid_i), .rx_data(rx_data_i),
    .rx_parity_err(rx_parity_err_i), .rx_overrun(rx_overrun_i),
    .rx_seen(rx_seen), .got_all(got_all),
    .err_overrun(err_overrun_o), .err_parity(err_parity_o), .err_data(err_data_o)
  );

  slt_timeout #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_to (
    .clk(clk), .rst(rst), .clear(start_go), .run(run),
    .kick(rx_seen), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
      led_q   <= '0;
    end else if (start_go) begin
      state_q <= ST_RUN;
      pass_q  <= 1'b0;
      led_q   <= '0;
    end else if (finish) begin
      state_q <= ST_DONE;
      pass_q  <= pass_next;
      led_q   <= {{(LED_W-1){1'b0}}, pass_next} << PASS_LED_BIT;
    end
  end

  assign busy_o        = run;
  assign done_o        = (state_q == ST_DONE);
  assign pass_o        = pass_q;
  assign err_timeout_o = expired;
  assign led_o         = led_q;

  // R8
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> done_o);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !tx_valid_o);

  // R8
  finish_sent_chk: assert property (@(posedge clk) disable iff (rst)
    (run && got_all) |-> sent_all);

  // R9
  timeout_fails_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_timeout_o) |-> !pass_o);

  // R10
  led_pass_chk: assert property (@(posedge clk) disable iff (rst)
    led_o[PASS_LED_BIT] == pass_o);

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (run && start_i && !finish) |=> run);
endmodule

// File: tb/serial_loopback_tester_bench.sv
`timescale 1ns/1ps
module serial_loopback_tester_bench;
  localparam int N   = 100;
  localparam int LAT = 3;
  localparam int PB  = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       tx_ready_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic       rx_parity_err_i = 1'b0;
  logic       rx_overrun_i = 1'b0;
  logic       tx_valid_o, busy_o, done_o, pass_o;
  logic       err_overrun_o, err_parity_o, err_data_o, err_timeout_o;
  logic [7:0] tx_data_o, led_o;

  serial_loopback_tester u_serial_loopback_tester (
    .clk(clk), .rst(rst), .start_i(start_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rx_parity_err_i(rx_parity_err_i), .rx_overrun_i(rx_overrun_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
    .err_overrun_o(err_overrun_o), .err_parity_o(err_parity_o),
    .err_data_o(err_data_o), .err_timeout_o(err_timeout_o), .led_o(led_o)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  logic [7:0] line_q[$];
  int         due_q[$];
  int cyc = 0, sent = 0, dlvd = 0, max_out = 0;
  int ovr_at = -1, par_at = -1, bad_at = -1, stop_at = 1 << 20, ready_mode = 0;
  bit man_valid = 0;
  logic [7:0] man_data = 8'h00;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Loopback model and scoreboard monitor
  initial begin
    logic [7:0] d, e;
    forever begin
      @(negedge clk);
      cyc++;
      rx_valid_i = 1'b0; rx_parity_err_i = 1'b0; rx_overrun_i = 1'b0;
      if (man_valid) begin
        rx_valid_i = 1'b1; rx_data_i = man_data;
        rx_parity_err_i = 1'b1; rx_overrun_i = 1'b1;
      end else if (line_q.size() > 0 && due_q[0] <= cyc && dlvd < stop_at) begin
        d = line_q.pop_front();
        void'(due_q.pop_front());
        rx_data_i       = (dlvd == bad_at) ? (d ^ 8'h40) : d;
        rx_parity_err_i = (dlvd == par_at);
        rx_overrun_i    = (dlvd == ovr_at);
        rx_valid_i      = 1'b1;
        dlvd++;
      end
      tx_ready_i = (ready_mode == 0) || ((cyc % 3) != 0);
      if (tx_valid_o && tx_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 extra character", int'(tx_data_o), -1);
        end else begin
          e = exp_q.pop_front();
          check(tx_data_o == e, "R3 tx pattern", int'(tx_data_o), int'(e));
        end
        line_q.push_back(tx_data_o);
        due_q.push_back(cyc + LAT);
        sent++;
      end
      if (sent - dlvd > max_out) max_out = sent - dlvd;
    end
  end

  task automatic stray_char();
    @(posedge clk);
    man_data = 8'h5A; man_valid = 1'b1;
    @(posedge clk);
    man_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input string name, input int ovr, input int par, input int bad,
                          input int stop, input int rmode, input bit e_ovr, input bit e_par,
                          input bit e_dat, input bit e_to, input bit restart_mid);
    bit e_pass;
    int w;
    e_pass = !(e_ovr || e_par || e_dat || e_to);
    @(posedge clk);
    ovr_at = ovr; par_at = par; bad_at = bad; stop_at = stop; ready_mode = rmode;
    line_q.delete(); due_q.delete(); exp_q.delete();
    sent = 0; dlvd = 0; max_out = 0;
    for (int i = 0; i < N; i++) exp_q.push_back(8'(i));
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    check(err_overrun_o == 0 && err_parity_o == 0 && err_data_o == 0 && err_timeout_o == 0,
          "R2 flags cleared at start",
          int'({err_overrun_o, err_parity_o, err_data_o, err_timeout_o}), 0);
    if (restart_mid) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    w = 0;
    while (!done_o && w < 5000) begin
      @(negedge clk);
      w++;
    end
    $display("case %s finished after %0d waits", name, w);
    check(done_o == 1'b1, "R8 done reached", int'(done_o), 1);
    check(busy_o == 1'b0, "R8 busy low when done", int'(busy_o), 0);
    check(pass_o == e_pass, "R8 pass result", int'(pass_o), int'(e_pass));
    check(err_overrun_o == e_ovr, "R5 overrun flag", int'(err_overrun_o), int'(e_ovr));
    check(err_parity_o == e_par, "R6 parity flag", int'(err_parity_o), int'(e_par));
    check(err_data_o == e_dat, "R7 data flag", int'(err_data_o), int'(e_dat));
    check(err_timeout_o == e_to, "R9 timeout flag", int'(err_timeout_o), int'(e_to));
    check(led_o == (8'(e_pass) << PB), "R10 led pattern", int'(led_o), int'(8'(e_pass) << PB));
    check(max_out <= 2, "R4 outstanding limit", max_out, 2);
    if (!e_to) begin
      check(sent == N && exp_q.size() == 0, "R3 exactly 100 sent", sent, N);
      check(dlvd == N, "R8 all received", dlvd, N);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tx_valid_o == 0, "R1 tx_valid reset", int'(tx_valid_o), 0);
    check(busy_o == 0 && done_o == 0, "R1 busy/done reset", int'({busy_o, done_o}), 0);
    check(pass_o == 0, "R1 pass reset", int'(pass_o), 0);
    check({err_overrun_o, err_parity_o, err_data_o, err_timeout_o} == 4'b0,
          "R1 flags reset", int'({err_overrun_o, err_parity_o, err_data_o, err_timeout_o}), 0);
    check(led_o == 8'h00, "R1 led reset", int'(led_o), 0);

    // R11 stray character while idle
    stray_char();
    check({err_overrun_o, err_parity_o, err_data_o, busy_o, done_o} == 5'b0,
          "R11 idle stray ignored",
          int'({err_overrun_o, err_parity_o, err_data_o, busy_o, done_o}), 0);

    run_case("clean_restart_mid", -1, -1, -1, 1 << 20, 1, 0, 0, 0, 0, 1);
    run_case("overrun", 10, -1, -1, 1 << 20, 0, 1, 0, 0, 0, 0);
    run_case("parity", -1, 50, -1, 1 << 20, 1, 0, 1, 0, 0, 0);
    run_case("mismatch_last", -1, -1, 99, 1 << 20, 0, 0, 0, 1, 0, 0);
    run_case("all_three", 0, 7, 33, 1 << 20, 1, 1, 1, 1, 0, 0);
    run_case("clean_after_fail", -1, -1, -1, 1 << 20, 0, 0, 0, 0, 0, 0);
    run_case("stall", -1, -1, -1, 20, 0, 0, 0, 0, 1, 0);

    // R11 stray character while done
    stray_char();
    check({err_overrun_o, err_parity_o, err_data_o} == 3'b0 && err_timeout_o && done_o,
          "R11 done stray ignored",
          int'({err_overrun_o, err_parity_o, err_data_o, err_timeout_o, done_o}), 3);

    run_case("final_clean", -1, -1, -1, 1 << 20, 1, 0, 0, 0, 0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule